// File: doc/BRIEF.md
# Converter Register Controller

This block is the bus-side control for a multi-channel analog-to-digital converter. Software sees two byte-wide registers on a simple register bus: a control/status register (completion flag, interrupt enable, repeat-mode select and a 5-bit channel field) and a result register. Writing the control register with a valid channel starts a conversion on an external converter through a start/abort/done/result handshake. The block stores the result, raises the completion flag and drives an interrupt line.

A sequencer state machine tracks the converter. Its states are `ST_IDLE` (nothing running), `ST_LAUNCH` (one-cycle start to the converter), `ST_BUSY` (waiting for done), `ST_SETTLE_GO` and `ST_SETTLE_RUN` (a warm-up conversion whose result is thrown away), and `ST_HALT` (stop request active). Its transitions are these:
- stop (any state to `ST_HALT` while the stop request is high)
- write-start (to `ST_LAUNCH`, or to `ST_SETTLE_GO` when a warm-up is owed)
- write-cancel (a write of a non-convertible channel, to `ST_IDLE`)
- launch (`ST_LAUNCH` to `ST_BUSY`)
- finish (`ST_BUSY` on done, to `ST_LAUNCH` in repeat mode, else to `ST_IDLE`)
- warm-up launch (`ST_SETTLE_GO` to `ST_SETTLE_RUN`)
- warm-up end (`ST_SETTLE_RUN` on done, to `ST_LAUNCH`)
- resume (`ST_HALT` after stop release, to `ST_SETTLE_GO` if repeat mode is on with a valid channel, else to `ST_IDLE`)

The wait-mode input leaves conversions running and only qualifies a wake output.

Top module: `adc_regctl`

## Requirements
- R1: After reset the control register reads 0x1F (bit 7 flag, bit 6 interrupt enable, bit 5 repeat mode, bits 4:0 channel). The result register reads 0, and irq, conv_pwr and conv_start are 0. The control register sits at bus address 0 and the result register at address 1.
- R2: A control write whose channel field is 0 to 6 pulses conv_start for one cycle, starting in the cycle after the write. The result is stored at done. In single-shot mode (bit 5 = 0) every completion sets bit 7. Only a stored conversion changes the result register.
- R3: A channel code of 7 to 30 starts nothing but keeps conv_pwr high. Code 31 starts nothing and drives conv_pwr low. Writing either code stops a running conversion.
- R4: In repeat mode (bit 5 = 1) conversions follow one another without further writes and the result register keeps updating. Bit 7 sets only on the first completion after the starting write.
- R5: With bit 6 = 0, bit 7 cannot be set by software. Any control write clears it, whatever is written to bit 7. A read strobe at the result address also clears it.
- R6: With bit 6 = 1, writing 0 to bit 7 clears the flag and writing 1 leaves it set.
- R7: irq goes high one cycle after bit 6 and bit 7 are both 1, and goes low one cycle after either clears. wake equals irq while wait_req is high and is 0 otherwise. Conversions proceed normally while wait_req is high.
- R8: A control write during a conversion raises conv_abort and restarts on the new channel. Only the new channel's result is stored.
- R9: While stop_req is high, conv_pwr is 0, no conversion starts, and a running conversion is abandoned with its result not stored.
- R10: The first conversion after stop_req falls is a warm-up, and its result is discarded. Repeat mode with a valid channel resumes by itself after the stop.
- R11: When a stored result and a flag-clearing access fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| wait_req | input | 1 | Low-power wait mode active |
| stop_req | input | 1 | Stop mode request |
| conv_start | output | 1 | Start pulse to the converter |
| conv_abort | output | 1 | Abandon the conversion in progress |
| conv_pwr | output | 1 | Converter power enable |
| conv_chan | output | 5 | Selected input channel |
| conv_done | input | 1 | Converter finished |
| conv_result | input | 8 | Converter result |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request while in wait mode |

## Verification
The delicate overlap is a conversion completing in the same cycle that software performs a flag-clearing read of the result register while interrupts are disabled. The bench starts a single-shot conversion against a converter model with a fixed latency and counts cycles from the write. It places the result-register read strobe exactly in the cycle that done is high, and confirms done was issued there. The flag must then read as set, and the result register must hold the freshly emitted value.

// File: rtl/adc_regctl_pkg.sv
`timescale 1ns/1ps
package adc_regctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_BUSY,
        ST_SETTLE_GO,
        ST_SETTLE_RUN,
        ST_HALT
    } seq_state_t;

endpackage

// File: rtl/adc_regctl_csr.sv
`timescale 1ns/1ps
module adc_regctl_csr #(
    parameter int BUS_W     = 8,
    parameter int ADDR_W    = 2,
    parameter int CSR_ADDR  = 0,
    parameter int DATA_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              result_valid,
    input  logic              set_flag,
    input  logic [BUS_W-1:0]  result,
    input  logic              wait_req,
    output logic              csr_wr,
    output logic              ien,
    output logic              cont,
    output logic [BUS_W-4:0]  chan,
    output logic              irq,
    output logic              wake
);
    localparam int CH_W     = BUS_W - 3;
    localparam int FLAG_BIT = BUS_W - 1;
    localparam int IEN_BIT  = BUS_W - 2;
    localparam int CONT_BIT = BUS_W - 3;
    localparam logic [ADDR_W-1:0] CSR_A  = ADDR_W'(CSR_ADDR);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

    logic             flag_q, ien_q, cont_q, irq_q;
    logic [CH_W-1:0]  chan_q;
    logic [BUS_W-1:0] data_q;
    logic             dat_rd, flag_clr;

    assign csr_wr = bus_wr && (bus_addr == CSR_A);
    assign dat_rd = bus_rd && (bus_addr == DATA_A);

    // flag clear rules depend on the enable held before this access
    always_comb begin
        if (ien_q) flag_clr = csr_wr && !bus_wdata[FLAG_BIT];
        else       flag_clr = csr_wr || dat_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            ien_q  <= 1'b0;
            cont_q <= 1'b0;
            chan_q <= '1;
            data_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (set_flag)      flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
            if (csr_wr) begin
                ien_q  <= bus_wdata[IEN_BIT];
                cont_q <= bus_wdata[CONT_BIT];
                chan_q <= bus_wdata[CH_W-1:0];
            end
            if (result_valid) data_q <= result;
            irq_q <= ien_q && flag_q;
        end
    end

    always_comb begin
        if (bus_addr == CSR_A)       bus_rdata = {flag_q, ien_q, cont_q, chan_q};
        else if (bus_addr == DATA_A) bus_rdata = data_q;
        else                         bus_rdata = '0;
    end

    assign ien  = ien_q;
    assign cont = cont_q;
    assign chan = chan_q;
    assign irq  = irq_q;
    assign wake = irq_q && wait_req;

    AST_FLAG_ONLY_HW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(set_flag)) else $error("flag set without result"); // R5
    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(flag_q) || $fell(ien_q)) |=> !irq_q) else $error("irq stuck"); // R7
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |=> $stable(data_q)) else $error("data changed"); // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_flag |=> flag_q) else $error("set lost"); // R11

endmodule

// File: rtl/adc_regctl_seq.sv
`timescale 1ns/1ps
module adc_regctl_seq
    import adc_regctl_pkg::*;
#(
    parameter int CH_W   = 5,
    parameter int NUM_CH = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_wr,
    input  logic [CH_W-1:0] wr_chan,
    input  logic [CH_W-1:0] cur_chan,
    input  logic            cur_cont,
    input  logic            stop_req,
    input  logic            conv_done,
    output logic            conv_start,
    output logic            conv_abort,
    output logic            conv_pwr,
    output logic            result_valid,
    output logic            set_flag
);
    localparam logic [CH_W-1:0] CH_LIMIT = CH_W'(NUM_CH);
    localparam logic [CH_W-1:0] PD_CODE  = '1;

    seq_state_t state_q, state_d;
    logic settle_q, first_q;
    logic start_req, resume_ok, running, settle_done, resume_go;

    assign start_req = csr_wr && (wr_chan < CH_LIMIT);
    assign resume_ok = cur_cont && (cur_chan < CH_LIMIT);
    assign resume_go = (state_q == ST_HALT) && !stop_req && !csr_wr && resume_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (stop_req) begin
            state_d = ST_HALT;
        end else if (csr_wr) begin
            if (start_req) state_d = settle_q ? ST_SETTLE_GO : ST_LAUNCH;
            else           state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:       state_d = ST_IDLE;
                ST_LAUNCH:     state_d = ST_BUSY;
                ST_BUSY:       if (conv_done) state_d = cur_cont ? ST_LAUNCH : ST_IDLE;
                ST_SETTLE_GO:  state_d = ST_SETTLE_RUN;
                ST_SETTLE_RUN: if (conv_done) state_d = ST_LAUNCH;
                ST_HALT:       state_d = resume_ok ? ST_SETTLE_GO : ST_IDLE;
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        running      = (state_q == ST_LAUNCH) || (state_q == ST_BUSY) ||
                       (state_q == ST_SETTLE_GO) || (state_q == ST_SETTLE_RUN);
        conv_start   = (state_q == ST_LAUNCH) || (state_q == ST_SETTLE_GO);
        conv_abort   = running && (stop_req || csr_wr);
        conv_pwr     = (cur_chan != PD_CODE) && (state_q != ST_HALT) && !stop_req;
        result_valid = (state_q == ST_BUSY) && conv_done && !stop_req && !csr_wr;
        settle_done  = (state_q == ST_SETTLE_RUN) && conv_done && !stop_req && !csr_wr;
        set_flag     = result_valid && (!cur_cont || first_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q <= 1'b0;
            first_q  <= 1'b0;
        end else begin
            if (stop_req)         settle_q <= 1'b1;
            else if (settle_done) settle_q <= 1'b0;
            if ((start_req && !stop_req) || resume_go) first_q <= 1'b1;
            else if (result_valid)                     first_q <= 1'b0;
        end
    end

    AST_START_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (cur_chan < CH_LIMIT)) else $error("bad channel start"); // R2
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && $past(stop_req)) |-> (!conv_start && !conv_pwr)) else $error("active in stop"); // R9
    AST_WARMUP_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        settle_q |-> !result_valid) else $error("warm-up stored"); // R10
    AST_PD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_chan == PD_CODE) |-> !conv_start) else $error("start while off"); // R3

endmodule

// File: rtl/adc_regctl.sv
`timescale 1ns/1ps
module adc_regctl #(
    parameter int BUS_W     = 8,
    parameter int ADDR_W    = 2,
    parameter int CSR_ADDR  = 0,
    parameter int DATA_ADDR = 1,
    parameter int NUM_CH    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              wait_req,
    input  logic              stop_req,
    output logic              conv_start,
    output logic              conv_abort,
    output logic              conv_pwr,
    output logic [BUS_W-4:0]  conv_chan,
    input  logic              conv_done,
    input  logic [BUS_W-1:0]  conv_result,
    output logic              irq,
    output logic              wake
);
    localparam int CH_W = BUS_W - 3;

    logic            csr_wr, ien_w, cont_w, result_valid, set_flag;
    logic [CH_W-1:0] chan_w;

    adc_regctl_csr #(
        .BUS_W(BUS_W), .ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR), .DATA_ADDR(DATA_ADDR)
    ) u_csr (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .result_valid(result_valid), .set_flag(set_flag), .result(conv_result),
        .wait_req(wait_req), .csr_wr(csr_wr), .ien(ien_w), .cont(cont_w),
        .chan(chan_w), .irq(irq), .wake(wake)
    );

    adc_regctl_seq #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .csr_wr(csr_wr), .wr_chan(bus_wdata[CH_W-1:0]),
        .cur_chan(chan_w), .cur_cont(cont_w),
        .stop_req(stop_req), .conv_done(conv_done),
        .conv_start(conv_start), .conv_abort(conv_abort), .conv_pwr(conv_pwr),
        .result_valid(result_valid), .set_flag(set_flag)
    );

    assign conv_chan = chan_w;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ien_w)) else $error("irq without enable"); // R7

endmodule

// File: tb/adc_regctl_bench.sv
`timescale 1ns/1ps
module adc_regctl_bench;
    localparam logic [1:0] A_CSR = 2'd0;
    localparam logic [1:0] A_DAT = 2'd1;
    localparam int LAT = 4;

    // {write data, expected control readback, expected conv_pwr, new result expected}
    localparam logic [17:0] VEC [7] = '{
        {8'h02, 8'h82, 1'b1, 1'b1},   // R2 single ch2
        {8'h05, 8'h85, 1'b1, 1'b1},   // R2 single ch5
        {8'h06, 8'h86, 1'b1, 1'b1},   // R2 highest channel
        {8'h87, 8'h07, 1'b1, 1'b0},   // R5 write of 1 clears, R3 code 7
        {8'h1F, 8'h1F, 1'b0, 1'b0},   // R3 power down
        {8'h23, 8'hA3, 1'b1, 1'b1},   // R4 repeat ch3
        {8'h1F, 8'h1F, 1'b0, 1'b0}    // R3 stops repeat
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wait_req = 1'b0, stop_req = 1'b0;
    logic       conv_start, conv_abort, conv_pwr, irq, wake;
    logic [4:0] conv_chan;
    logic       conv_done = 1'b0;
    logic [7:0] conv_result = '0;

    int total = 0, bad = 0;
    int emit_cnt = 0, start_cnt = 0, cnt = 0;

    always #4 clk = ~clk;

    adc_regctl u_adc_regctl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wait_req(wait_req), .stop_req(stop_req),
        .conv_start(conv_start), .conv_abort(conv_abort), .conv_pwr(conv_pwr),
        .conv_chan(conv_chan), .conv_done(conv_done), .conv_result(conv_result),
        .irq(irq), .wake(wake)
    );

    // converter model: fixed latency, result = {channel[2:0], emission count[4:0]}
    always @(negedge clk) begin
        conv_done <= 1'b0;
        if (conv_start) begin
            cnt <= LAT;
            start_cnt <= start_cnt + 1;
        end else if (conv_abort || !conv_pwr) begin
            cnt <= 0;
        end else if (cnt == 1) begin
            cnt <= 0;
            conv_done <= 1'b1;
            conv_result <= {conv_chan[2:0], 5'(emit_cnt + 1)};
            emit_cnt <= emit_cnt + 1;
        end else if (cnt > 1) begin
            cnt <= cnt - 1;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        step();
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_emit(input int target);
        for (int k = 0; k < 200 && emit_cnt < target; k++) step();
    endtask

    task automatic wait_flag();
        logic [7:0] v;
        for (int k = 0; k < 200; k++) begin
            step();
            peek(A_CSR, v);
            if (v[7]) break;
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [7:0] v, d0;
        int e0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        peek(A_CSR, v); chk("R1 csr", v, 8'h1F);
        peek(A_DAT, v); chk("R1 data", v, 8'h00);
        chk("R1 irq/pwr/start", {5'd0, irq, conv_pwr, conv_start}, 8'h00);

        // table of basic writes
        for (int i = 0; i < 7; i++) begin
            wr(A_CSR, VEC[i][17:10]);
            repeat (14) step();
            peek(A_CSR, v); chk("R2/R3/R4/R5 csr", v, VEC[i][9:2]);
            chk("R3 pwr", {7'd0, conv_pwr}, {7'd0, VEC[i][1]});
            if (VEC[i][0]) begin
                peek(A_DAT, v); chk("R2 data channel", {5'd0, v[7:5]}, {5'd0, VEC[i][12:10]});
            end
        end

        // R5 result read clears flag
        wr(A_CSR, 8'h01); wait_flag();
        step(); bus_addr = A_DAT; bus_rd = 1'b1; step(); bus_rd = 1'b0;
        peek(A_CSR, v); chk("R5 read clears", v, 8'h01);

        // R4 flag only after first completion
        e0 = emit_cnt;
        wr(A_CSR, 8'h24); wait_emit(e0 + 1); step(); step();
        step(); bus_addr = A_DAT; bus_rd = 1'b1; step(); bus_rd = 1'b0;
        e0 = emit_cnt; wait_emit(e0 + 2); step(); step();
        peek(A_CSR, v); chk("R4 no second flag", v, 8'h24);
        peek(A_DAT, v); chk("R4 data updates", v, conv_result);
        wr(A_CSR, 8'h1F);
        repeat (8) step();

        // R6/R7 interrupt flag handling
        wr(A_CSR, 8'h42); wait_flag();
        chk("R7 irq lag", {7'd0, irq}, 8'h00);
        step(); chk("R7 irq high", {7'd0, irq}, 8'h01);
        wr(A_CSR, 8'hC7);
        peek(A_CSR, v); chk("R6 write 1 keeps", v, 8'hC7);
        wr(A_CSR, 8'h47);
        peek(A_CSR, v); chk("R6 write 0 clears", v, 8'h47);
        chk("R7 irq still high", {7'd0, irq}, 8'h01);
        step(); chk("R7 irq dropped", {7'd0, irq}, 8'h00);

        // R7 wait mode
        wait_req = 1'b1;
        wr(A_CSR, 8'h40); wait_flag(); step();
        chk("R7 wake", {7'd0, wake}, 8'h01);
        peek(A_DAT, v); chk("R7 conversion in wait", {5'd0, v[7:5]}, 8'h00);
        wait_req = 1'b0; #1;
        chk("R7 no wake", {6'd0, irq, wake}, 8'h02);
        wr(A_CSR, 8'h1F);
        repeat (8) step();

        // R8 restart mid-conversion
        e0 = emit_cnt;
        wr(A_CSR, 8'h01); wr(A_CSR, 8'h05);
        repeat (15) step();
        peek(A_DAT, v); chk("R8 new channel", {5'd0, v[7:5]}, 8'h05);
        chk("R8 one result", 8'(emit_cnt - e0), 8'h01);

        // R11 completion and clearing read in the same cycle
        e0 = emit_cnt;
        wr(A_CSR, 8'h02);
        repeat (4) step();
        chk("R11 done aligned", 8'(emit_cnt - e0), 8'h01);
        bus_addr = A_DAT; bus_rd = 1'b1; step(); bus_rd = 1'b0;
        peek(A_CSR, v); chk("R11 set wins", v, 8'h82);
        peek(A_DAT, v); chk("R11 data", v, conv_result);

        // R9/R10 stop, warm-up, resume
        wr(A_CSR, 8'h23);
        repeat (10) step();
        stop_req = 1'b1; #1;
        chk("R9 pwr off", {7'd0, conv_pwr}, 8'h00);
        repeat (3) step();
        peek(A_DAT, d0);
        e0 = start_cnt;
        repeat (10) step();
        chk("R9 no starts", 8'(start_cnt - e0), 8'h00);
        peek(A_DAT, v); chk("R9 no store", v, d0);
        e0 = emit_cnt;
        stop_req = 1'b0;
        wait_emit(e0 + 1); step();
        peek(A_DAT, v); chk("R10 warm-up discarded", v, d0);
        wait_emit(e0 + 2); step();
        peek(A_DAT, v); chk("R10 resumed result", v, conv_result);
        wr(A_CSR, 8'h1F);
        repeat (4) step();

        summary();
    end

endmodule